// File: doc/BRIEF.md
# Single-Lane Structure Store Unit

This unit carries out one vector store of a single structure taken from one lane. A descriptor names a structure size n (1 to 4 elements), an element width (8, 16 or 32 bits), a lane index, a first vector register and a register spacing. Element k of the structure is read from the chosen lane of vector register `first + k*spacing` in a 32-entry file of 64-bit registers. The n elements are then written as one packed structure to a byte-wide memory stream.

The unit checks each descriptor once, when it is accepted. An illegal field combination, or a base address that misses an alignment qualifier, ends the operation at once with a flag and no memory traffic. Otherwise the unit reads the registers one per cycle, sends the structure one byte per handshake, and reports the new base value. The base value either stays as it is, grows by the number of bytes sent, or grows by an offset register value.

The memory side is valid/ready. The unit raises `mem_valid_o` and keeps address and data fixed until `mem_ready_i` is seen high on a rising clock edge. The consumer may hold `mem_ready_i` low for any number of cycles. The descriptor side is also valid/ready, and `cmd_ready_o` is high only while the unit is idle.

Top module: `lane_struct_store`

## Requirements
- R1: `cmd_ready_o` is high exactly when the unit is idle, which includes after reset. A descriptor is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` is low in the following cycle.
- R2: Field encodings are as follows. `cmd_count_i` is n-1. `cmd_size_i` is 0, 1 or 2 for 8-, 16- or 32-bit elements, and 3 is illegal. Element k is read from lane `cmd_lane_i` of register `cmd_reg_i + k*s`, where s is 2 when `cmd_stride2_i` is set and 1 otherwise. The element is written at address base + k*E + b, where E is the element size in bytes, and byte b is bits [8b+7:8b] of the element (little-endian). Lane L of element size E occupies register bits starting at 8*L*E.
- R3: One byte moves per cycle in which `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold their values.
- R4: Spacing 2 with n=1, or spacing 2 with 8-bit elements, is an illegal encoding.
- R5: If `cmd_reg_i + (n-1)*s` exceeds 31, the encoding is illegal.
- R6: A lane index above 7, 3 or 1 for 8-, 16- or 32-bit elements is an illegal encoding.
- R7: `cmd_align_i` codes are 0 for none, 1 for 2 bytes, 2 for 4 bytes, 3 for 8 bytes and 4 for 16 bytes. Code 0 is always legal. The other legal codes are: n=1 with 16-bit allows 1; n=1 with 32-bit allows 2; n=2 allows 1, 2 or 3 for 8-, 16- or 32-bit; n=4 allows 2 for 8-bit, 3 for 16-bit, and 3 or 4 for 32-bit. Every other code is an illegal encoding, which includes every nonzero code for n=3 and for n=1 with 8-bit elements.
- R8: `cmd_base_idx_i` equal to 15 is illegal. In register-offset mode, `cmd_off_idx_i` equal to 13 or 15 is illegal.
- R9: On a legal descriptor with a nonzero alignment code, a base that is not a multiple of the qualifier raises `align_fault_o`. In that case no memory beat is issued, `base_we_o` stays low, and `base_o` equals the old base.
- R10: With alignment code 0, any base address is accepted and the store proceeds.
- R11: `cmd_wb_i` codes are 0 for no update, 1 for immediate, 2 for register offset, and 3 for illegal. In immediate mode, a completed store reports `base_we_o`=1 and `base_o` = base + n*E.
- R12: In register-offset mode, the bytes are written starting at the unmodified base, and `base_o` = base + `cmd_offset_i`.
- R13: `done_o` is a one-cycle pulse. It follows the acceptance of the last byte, or it comes in the cycle right after an illegal or faulting descriptor is accepted. `illegal_o`, `align_fault_o` and `base_we_o` are valid only together with `done_o`, and `illegal_o` and `align_fault_o` are never high together. An illegal descriptor issues no memory beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Descriptor offered |
| cmd_ready_o | output | 1 | Unit idle, descriptor can be taken |
| cmd_count_i | input | 2 | Structure size minus one |
| cmd_size_i | input | 2 | Element width code |
| cmd_lane_i | input | 3 | Lane index |
| cmd_reg_i | input | 5 | First vector register |
| cmd_stride2_i | input | 1 | Register spacing of 2 |
| cmd_align_i | input | 3 | Alignment qualifier code |
| cmd_wb_i | input | 2 | Base update mode |
| cmd_base_idx_i | input | 4 | Index of scalar base register |
| cmd_off_idx_i | input | 4 | Index of scalar offset register |
| cmd_base_i | input | 32 | Base address value |
| cmd_offset_i | input | 32 | Offset register value |
| vrf_addr_o | output | 5 | Vector register read address |
| vrf_data_i | input | 64 | Vector register read data, same cycle |
| mem_valid_o | output | 1 | Memory byte beat valid |
| mem_ready_i | input | 1 | Memory accepts beat |
| mem_addr_o | output | 32 | Byte address |
| mem_data_o | output | 8 | Byte data |
| done_o | output | 1 | Operation finished pulse |
| illegal_o | output | 1 | Illegal encoding flag |
| align_fault_o | output | 1 | Alignment fault flag |
| base_we_o | output | 1 | Base update valid |
| base_o | output | 32 | Resulting base value |

## Verification
The store path is run with a single byte (n=1, 8-bit, high lane), a full 16-byte structure from the top registers, a spaced 16-bit pair, and a spaced three-element structure at an odd base. Together these separate errors in lane offset, register stepping, byte order and address increment. Each is run with the memory always ready and again under a pseudo-random stall pattern, which shows whether beats are held or dropped. Legality is probed with pairs that sit one step either side of each rule: the last legal register against the first out-of-range one, the top legal lane against the next, and an allowed alignment code against a refused one. Aligned and misaligned bases are run under the same qualifier, and offset-register indices are tried both in and out of register-offset mode.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_SEND, ST_FIN} sls_state_e;
  typedef enum logic [1:0] {WB_NONE = 2'd0, WB_IMM = 2'd1, WB_REG = 2'd2, WB_BAD = 2'd3} sls_wb_e;
  localparam logic [1:0] SZ_BAD   = 2'd3;
  localparam logic [3:0] IDX_PC   = 4'd15;
  localparam logic [3:0] IDX_SP   = 4'd13;
endpackage

// File: rtl/sls_legal.sv
module sls_legal #(
  parameter int REG_N  = 32,
  parameter int LANE_W = 3,
  localparam int REG_W = $clog2(REG_N)
) (
  input  logic [1:0]        cnt_i,
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic              sp2_i,
  input  logic [2:0]        align_i,
  input  logic [1:0]        wb_i,
  input  logic [3:0]        base_idx_i,
  input  logic [3:0]        off_idx_i,
  input  logic [4:0]        base_low_i,
  output logic              illegal_o,
  output logic              misalign_o,
  output logic [4:0]        nbytes_o
);
  import sls_pkg::*;

  logic [7:0] ok_codes;
  logic       lane_ok, reg_ok, sp_ok, idx_ok;
  int         last_reg, lane_max;
  logic [4:0] mask;

  always_comb begin
    ok_codes = 8'b0000_0001;
    unique case (cnt_i)
      2'd0: begin
        if (size_i == 2'd1) ok_codes[1] = 1'b1;
        if (size_i == 2'd2) ok_codes[2] = 1'b1;
      end
      2'd1: begin
        if (size_i == 2'd0) ok_codes[1] = 1'b1;
        if (size_i == 2'd1) ok_codes[2] = 1'b1;
        if (size_i == 2'd2) ok_codes[3] = 1'b1;
      end
      2'd2: ;
      default: begin
        if (size_i == 2'd0) ok_codes[2] = 1'b1;
        if (size_i == 2'd1) ok_codes[3] = 1'b1;
        if (size_i == 2'd2) ok_codes[4:3] = 2'b11;
      end
    endcase

    lane_max = (1 << (LANE_W - int'(size_i))) - 1;
    lane_ok  = (size_i != SZ_BAD) && (int'(lane_i) <= lane_max);
    last_reg = int'(reg_i) + int'(cnt_i) * (sp2_i ? 2 : 1);
    reg_ok   = last_reg < REG_N;
    sp_ok    = !sp2_i || ((cnt_i != 2'd0) && (size_i != 2'd0));
    idx_ok   = (base_idx_i != IDX_PC) && (wb_i != WB_BAD) &&
               !((wb_i == WB_REG) && ((off_idx_i == IDX_SP) || (off_idx_i == IDX_PC)));

    illegal_o  = !(lane_ok && reg_ok && sp_ok && idx_ok && ok_codes[align_i]);
    mask       = (5'd1 << align_i) - 5'd1;
    misalign_o = !illegal_o && (align_i != 3'd0) && ((base_low_i & mask) != 5'd0);
    nbytes_o   = 5'(({3'b000, cnt_i} + 5'd1) << size_i);
  end
endmodule

// File: rtl/sls_lane_pick.sv
module sls_lane_pick #(
  parameter int VREG_W = 64,
  localparam int LANE_W = $clog2(VREG_W / 8),
  localparam int NBYTE  = VREG_W / 8
) (
  input  logic [VREG_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [1:0]        size_i,
  output logic [31:0]       elem_o
);
  int pos;
  always_comb begin
    elem_o = '0;
    for (int b = 0; b < 4; b++) begin
      pos = int'(lane_i) * (1 << size_i) + b;
      if (b < (1 << size_i) && pos < NBYTE) elem_o[8*b +: 8] = word_i[8*pos +: 8];
    end
  end
endmodule

// File: rtl/lane_struct_store.sv
module lane_struct_store #(
  parameter int ADDR_W = 32,
  parameter int VREG_N = 32,
  parameter int VREG_W = 64,
  localparam int REG_W  = $clog2(VREG_N),
  localparam int LANE_W = $clog2(VREG_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_count_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [LANE_W-1:0] cmd_lane_i,
  input  logic [REG_W-1:0]  cmd_reg_i,
  input  logic              cmd_stride2_i,
  input  logic [2:0]        cmd_align_i,
  input  logic [1:0]        cmd_wb_i,
  input  logic [3:0]        cmd_base_idx_i,
  input  logic [3:0]        cmd_off_idx_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [ADDR_W-1:0] cmd_offset_i,
  output logic [REG_W-1:0]  vrf_addr_o,
  input  logic [VREG_W-1:0] vrf_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              align_fault_o,
  output logic              base_we_o,
  output logic [ADDR_W-1:0] base_o
);
  import sls_pkg::*;

  localparam int MAX_N     = 4;
  localparam int MAX_EB    = 4;
  localparam int BUF_BYTES = MAX_N * MAX_EB;
  localparam int IDX_W     = $clog2(BUF_BYTES);

  sls_state_e        state_q;
  logic [1:0]        cnt_q, size_q, k_q;
  logic [LANE_W-1:0] lane_q;
  logic [REG_W-1:0]  reg_q;
  logic              sp2_q, we_q, ill_q, flt_q;
  logic [ADDR_W-1:0] base_q, newbase_q;
  logic [4:0]        nbytes_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        buf_q [BUF_BYTES];

  logic              chk_ill, chk_flt;
  logic [4:0]        chk_nbytes;
  logic [31:0]       elem;

  sls_legal #(.REG_N(VREG_N), .LANE_W(LANE_W)) u_legal (
    .cnt_i(cmd_count_i), .size_i(cmd_size_i), .lane_i(cmd_lane_i), .reg_i(cmd_reg_i),
    .sp2_i(cmd_stride2_i), .align_i(cmd_align_i), .wb_i(cmd_wb_i),
    .base_idx_i(cmd_base_idx_i), .off_idx_i(cmd_off_idx_i), .base_low_i(cmd_base_i[4:0]),
    .illegal_o(chk_ill), .misalign_o(chk_flt), .nbytes_o(chk_nbytes)
  );

  sls_lane_pick #(.VREG_W(VREG_W)) u_pick (
    .word_i(vrf_data_i), .lane_i(lane_q), .size_i(size_q), .elem_o(elem)
  );

  assign vrf_addr_o    = reg_q + REG_W'(k_q) * (sp2_q ? REG_W'(2) : REG_W'(1));
  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign mem_valid_o   = (state_q == ST_SEND);
  assign mem_addr_o    = base_q + ADDR_W'(idx_q);
  assign mem_data_o    = buf_q[idx_q];
  assign done_o        = (state_q == ST_FIN);
  assign illegal_o     = done_o && ill_q;
  assign align_fault_o = done_o && flt_q;
  assign base_we_o     = done_o && we_q;
  assign base_o        = we_q ? newbase_q : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q <= '0; size_q <= '0; k_q <= '0; lane_q <= '0; reg_q <= '0;
      sp2_q <= 1'b0; we_q <= 1'b0; ill_q <= 1'b0; flt_q <= 1'b0;
      base_q <= '0; newbase_q <= '0; nbytes_q <= '0; idx_q <= '0;
      for (int p = 0; p < BUF_BYTES; p++) buf_q[p] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          cnt_q    <= cmd_count_i;
          size_q   <= cmd_size_i;
          lane_q   <= cmd_lane_i;
          reg_q    <= cmd_reg_i;
          sp2_q    <= cmd_stride2_i;
          base_q   <= cmd_base_i;
          nbytes_q <= chk_nbytes;
          ill_q    <= chk_ill;
          flt_q    <= chk_flt;
          we_q     <= !chk_ill && !chk_flt && (cmd_wb_i != WB_NONE);
          newbase_q <= (cmd_wb_i == WB_REG) ? cmd_base_i + cmd_offset_i
                                            : cmd_base_i + ADDR_W'(chk_nbytes);
          k_q      <= '0;
          idx_q    <= '0;
          state_q  <= (chk_ill || chk_flt) ? ST_FIN : ST_GATHER;
        end
        ST_GATHER: begin
          for (int p = 0; p < BUF_BYTES; p++) begin
            if (p >= (int'(k_q) << size_q) && p < ((int'(k_q) + 1) << size_q))
              buf_q[p] <= elem[8*(p - (int'(k_q) << size_q)) +: 8];
          end
          if (k_q == cnt_q) state_q <= ST_SEND;
          else k_q <= k_q + 2'd1;
        end
        ST_SEND: if (mem_ready_i) begin
          if (5'(idx_q) == nbytes_q - 5'd1) state_q <= ST_FIN;
          else idx_q <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_ready_i) |=> (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + 1));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_flag_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_o, align_fault_o}));
  assert_flag_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o || align_fault_o || base_we_o) |-> done_o);
  assert_fault_nowb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> !base_we_o);
  assert_bad_nomem_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && (chk_ill || chk_flt)) |=> done_o);
endmodule

// File: tb/lane_struct_store_tb_top.sv
module lane_struct_store_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_count = '0, cmd_size = '0, cmd_wb = '0;
  logic [2:0] cmd_lane = '0, cmd_align = '0;
  logic [4:0] cmd_reg = '0, vrf_addr;
  logic cmd_stride2 = 1'b0;
  logic [3:0] cmd_base_idx = '0, cmd_off_idx = '0;
  logic [31:0] cmd_base = '0, cmd_offset = '0, mem_addr, base_out;
  logic [63:0] vrf_data;
  logic mem_valid, mem_ready, done, illegal, align_fault, base_we;
  logic [7:0] mem_data;

  logic [63:0] vreg [32];
  assign vrf_data = vreg[vrf_addr];

  int checks = 0, failures = 0, cycles = 0;
  logic [39:0] exp_q[$];
  bit exp_ill, exp_flt, exp_we, got_done = 0, stall_mode = 0;
  logic [31:0] exp_base;
  string cur_tag = "R1";
  logic [7:0] lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_struct_store dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_count_i(cmd_count), .cmd_size_i(cmd_size), .cmd_lane_i(cmd_lane), .cmd_reg_i(cmd_reg),
    .cmd_stride2_i(cmd_stride2), .cmd_align_i(cmd_align), .cmd_wb_i(cmd_wb),
    .cmd_base_idx_i(cmd_base_idx), .cmd_off_idx_i(cmd_off_idx), .cmd_base_i(cmd_base),
    .cmd_offset_i(cmd_offset), .vrf_addr_o(vrf_addr), .vrf_data_i(vrf_data),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .done_o(done), .illegal_o(illegal), .align_fault_o(align_fault), .base_we_o(base_we), .base_o(base_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin lfsr <= 8'h5B; mem_ready <= 1'b1; end
    else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready <= !stall_mode || lfsr[0];
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (mem_valid && mem_ready) begin
      if (exp_q.size() == 0) chk(cur_tag, "unexpected beat", 1, 0);
      else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        chk(cur_tag, "addr", mem_addr, e[39:8]);
        chk(cur_tag, "data", mem_data, e[7:0]);
      end
    end
    if (done) begin
      chk(cur_tag, "illegal", illegal, exp_ill);
      chk(cur_tag, "align_fault", align_fault, exp_flt);
      chk(cur_tag, "base_we", base_we, exp_we);
      chk(cur_tag, "base", base_out, exp_base);
      chk(cur_tag, "bytes left", exp_q.size(), 0);
      got_done = 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 60000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_cmd(string tag, int n, int sz, int lane, int rg, bit sp2, int al,
                         int wb, int bi, int oi, logic [31:0] base, logic [31:0] off);
    bit bad = 0;
    logic [7:0] okm = 8'h01;
    int esz = 1 << sz;
    int step = sp2 ? 2 : 1;
    cur_tag = tag;
    if (sz == 3 || wb == 3 || bi == 15) bad = 1;
    if (wb == 2 && (oi == 13 || oi == 15)) bad = 1;
    if (sz < 3 && lane >= (8 >> sz)) bad = 1;
    if (sp2 && (n == 1 || sz == 0)) bad = 1;
    if (rg + (n - 1) * step > 31) bad = 1;
    case (n)
      1: begin if (sz == 1) okm[1] = 1; if (sz == 2) okm[2] = 1; end
      2: begin if (sz == 0) okm[1] = 1; if (sz == 1) okm[2] = 1; if (sz == 2) okm[3] = 1; end
      4: begin if (sz == 0) okm[2] = 1; if (sz == 1) okm[3] = 1; if (sz == 2) begin okm[3] = 1; okm[4] = 1; end end
      default: ;
    endcase
    if (!okm[al]) bad = 1;
    exp_ill = bad;
    exp_flt = !bad && al != 0 && (base % (32'd1 << al)) != 0;
    exp_we = !exp_ill && !exp_flt && wb != 0;
    exp_base = !exp_we ? base : (wb == 2 ? base + off : base + 32'(n * esz));
    if (!exp_ill && !exp_flt)
      for (int k = 0; k < n; k++)
        for (int b = 0; b < esz; b++)
          exp_q.push_back({base + 32'(k * esz + b), vreg[rg + k * step][8 * (lane * esz + b) +: 8]});
    @(negedge clk);
    chk("R1", "cmd_ready idle", cmd_ready, 1);
    cmd_count = 2'(n - 1); cmd_size = 2'(sz); cmd_lane = 3'(lane); cmd_reg = 5'(rg);
    cmd_stride2 = sp2; cmd_align = 3'(al); cmd_wb = 2'(wb); cmd_base_idx = 4'(bi);
    cmd_off_idx = 4'(oi); cmd_base = base; cmd_offset = off; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk("R1", "cmd_ready busy", cmd_ready, 0);
    wait (got_done);
    got_done = 0;
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 8; j++) vreg[i][8*j +: 8] = 8'(i * 8 + j) ^ 8'hA5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "reset cmd_ready", cmd_ready, 1);
    chk("R13", "reset done", done, 0);
    chk("R3", "reset mem_valid", mem_valid, 0);
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      run_cmd("R2", 1, 0, 7, 3, 0, 0, 0, 2, 0, 32'h0000_0013, 0);
      run_cmd("R11", 4, 2, 1, 28, 0, 4, 1, 2, 0, 32'h0000_0100, 0);
      run_cmd("R12", 2, 1, 3, 10, 1, 2, 2, 4, 5, 32'h0000_0204, 32'h40);
      run_cmd("R10", 3, 1, 2, 0, 1, 0, 1, 1, 0, 32'h0000_1003, 0);
      run_cmd("R3", 4, 0, 6, 12, 0, 2, 1, 0, 0, 32'h0000_2008, 0);
    end
    stall_mode = 0;
    run_cmd("R9", 4, 1, 0, 4, 0, 3, 1, 0, 0, 32'h0000_0104, 0);
    run_cmd("R9", 2, 2, 0, 4, 0, 3, 2, 0, 1, 32'h0000_0108, 32'h10);
    run_cmd("R4", 1, 1, 0, 4, 1, 0, 0, 0, 0, 0, 0);
    run_cmd("R4", 2, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0);
    run_cmd("R5", 4, 2, 0, 29, 0, 0, 1, 0, 0, 0, 0);
    run_cmd("R5", 4, 2, 0, 26, 1, 0, 1, 0, 0, 0, 0);
    run_cmd("R5", 4, 2, 0, 25, 1, 0, 1, 0, 0, 32'h40, 0);
    run_cmd("R6", 1, 1, 4, 1, 0, 0, 0, 0, 0, 0, 0);
    run_cmd("R6", 1, 2, 2, 1, 0, 0, 0, 0, 0, 0, 0);
    run_cmd("R6", 1, 2, 1, 1, 0, 0, 1, 0, 0, 32'h80, 0);
    run_cmd("R7", 3, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    run_cmd("R7", 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    run_cmd("R7", 2, 2, 0, 1, 0, 4, 0, 0, 0, 0, 0);
    run_cmd("R7", 4, 2, 0, 1, 0, 3, 1, 0, 0, 32'h18, 0);
    run_cmd("R7", 2, 0, 5, 1, 0, 1, 1, 0, 0, 32'h1E, 0);
    run_cmd("R8", 1, 0, 0, 1, 0, 0, 1, 15, 0, 0, 0);
    run_cmd("R8", 1, 0, 0, 1, 0, 0, 2, 0, 13, 0, 0);
    run_cmd("R8", 1, 0, 0, 1, 0, 0, 2, 0, 15, 0, 0);
    run_cmd("R8", 1, 0, 0, 1, 0, 0, 1, 0, 13, 32'h30, 0);
    run_cmd("R2", 1, 3, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run_cmd("R11", 1, 0, 0, 1, 0, 0, 3, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule